// File: doc/BRIEF.md
# Serial Converter Read Controller

This block is the master side of a three-wire serial link to an external analog-to-digital converter that signals the end of its conversion on its own data line. A single-cycle start request drops the active-low select line. That falling edge starts the conversion, and the controller then holds select low and keeps its serial clock quiet. The converter keeps its data line low while it is converting and raises it once the result is ready. When the controller sees that high level, it runs a burst of serial clocks and samples the data line on every rising clock edge.

The burst is thirteen clocks long. The first sample is the high completion level. The next ten samples are the result, most significant bit first, and the last two are extra sub-bits. The ten-bit result and the two sub-bits come out on separate registered outputs, together with a one-cycle valid pulse. The select line rises in that same cycle, so the bus stays claimed for the whole conversion and readout. A timeout counter limits the wait for completion. If the data line stays low for the whole timeout window, the controller releases select and pulses an error flag instead of reading.

Top module: `sadc_reader`

## Requirements
- R1: While reset is held and in the first cycle after it, cs_n_o is 1, and sclk_o, busy_o, valid_o and err_o are 0.
- R2: start_i is acted on only while busy_o is 0. A start pulse while busy_o is 1 causes no extra falling edge on cs_n_o and does not change the transfer in progress.
- R3: cs_n_o falls in the cycle after an accepted start and stays low until the cycle in which valid_o or err_o is 1. busy_o equals the inverse of cs_n_o at all times.
- R4: sclk_o is 0 whenever cs_n_o is 1, and sclk_o shows no edge while miso_i is still low during the conversion wait.
- R5: After miso_i is seen high, exactly 13 rising edges appear on sclk_o, each HALF_DIV cycles high and HALF_DIV cycles low. No rising edges appear in a transfer that times out.
- R6: Sample k (k = 0..12) is taken at the k-th rising edge of sclk_o. Sample 0 is the completion level, samples 1..10 form data_o from bit 9 down to bit 0, and samples 11..12 form sub_o from bit 1 down to bit 0.
- R7: valid_o is a single-cycle pulse. In that cycle cs_n_o is 1 and busy_o is 0, and data_o and sub_o already hold the new values.
- R8: If miso_i stays low for TIMEOUT_CYC cycles after cs_n_o falls, err_o pulses for one cycle and cs_n_o rises in that same cycle. cs_n_o is therefore low for exactly TIMEOUT_CYC cycles, and valid_o stays 0.
- R9: data_o and sub_o change only in a valid_o cycle, so a timed-out transfer leaves the previous result on them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to run one conversion and readout |
| miso_i | input | 1 | Converter data line, also the completion flag |
| cs_n_o | output | 1 | Active-low converter select |
| sclk_o | output | 1 | Serial clock to the converter |
| busy_o | output | 1 | High from an accepted start until valid or error |
| valid_o | output | 1 | One-cycle pulse marking a new result |
| err_o | output | 1 | One-cycle pulse marking a completion timeout |
| data_o | output | DATA_W | Ten-bit conversion result |
| sub_o | output | SUB_W | Captured trailing sub-bits |

## Verification
The checks assume that reset is applied from time zero and that miso_i changes only away from a rising sclk_o edge. This matches a converter that shifts its data on the falling clock edge. The stimulus model of the converter changes its line just after each falling sclk_o edge and just after the select line falls. It is never clocked past the frame, and start is always driven as a one-cycle pulse between clock edges.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_SHIFT = 2'd2
  } sadc_state_e;
endpackage

// File: rtl/sadc_sclk_gen.sv
module sadc_sclk_gen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic sclk_o,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [DW-1:0] div_q;
  logic          wrap;

  assign wrap      = (div_q == DW'(HALF_DIV - 1));
  assign rise_tick = en && wrap && !sclk_o;
  assign fall_tick = en && wrap && sclk_o;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      div_q  <= '0;
      sclk_o <= 1'b0;
    end else if (wrap) begin
      div_q  <= '0;
      sclk_o <= ~sclk_o;
    end else begin
      div_q  <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/sadc_eoc_timer.sv
module sadc_eoc_timer #(
  parameter int LIMIT = 750
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  assign expired = (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (!expired) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sadc_shift_in.sv
module sadc_shift_in #(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             shift,
  input  logic             din,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      q <= '0;
    end else if (shift) begin
      q <= {q[WIDTH-2:0], din};
    end
  end
endmodule

// File: rtl/sadc_reader.sv
module sadc_reader #(
  parameter int DATA_W      = 10,
  parameter int SUB_W       = 2,
  parameter int LEAD_W      = 1,
  parameter int HALF_DIV    = 2,
  parameter int TIMEOUT_CYC = 750
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              miso_i,
  output logic              cs_n_o,
  output logic              sclk_o,
  output logic              busy_o,
  output logic              valid_o,
  output logic              err_o,
  output logic [DATA_W-1:0] data_o,
  output logic [SUB_W-1:0]  sub_o
);
  import sadc_pkg::*;

  localparam int FRAME = LEAD_W + DATA_W + SUB_W;
  localparam int PAY_W = DATA_W + SUB_W;
  localparam int RCW   = $clog2(FRAME + 1);

  sadc_state_e      state_q;
  logic [RCW-1:0]   rises_q;
  logic             rise_tick, fall_tick, expired;
  logic             accept, last_edge;
  logic [PAY_W-1:0] sr_q;

  assign accept    = (state_q == ST_IDLE) && start_i;
  assign last_edge = (state_q == ST_SHIFT) && fall_tick && (rises_q == RCW'(FRAME));

  sadc_sclk_gen #(.HALF_DIV(HALF_DIV)) u_clkgen (
    .clk       (clk),
    .rst       (rst),
    .en        (state_q == ST_SHIFT),
    .sclk_o    (sclk_o),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  sadc_eoc_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .run     (state_q == ST_CONV),
    .expired (expired)
  );

  sadc_shift_in #(.WIDTH(PAY_W)) u_shift (
    .clk   (clk),
    .rst   (rst),
    .clear (accept),
    .shift (rise_tick && (state_q == ST_SHIFT)),
    .din   (miso_i),
    .q     (sr_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      rises_q <= '0;
      cs_n_o  <= 1'b1;
      busy_o  <= 1'b0;
      valid_o <= 1'b0;
      err_o   <= 1'b0;
      data_o  <= '0;
      sub_o   <= '0;
    end else begin
      valid_o <= 1'b0;
      err_o   <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          rises_q <= '0;
          if (accept) begin
            state_q <= ST_CONV;
            cs_n_o  <= 1'b0;
            busy_o  <= 1'b1;
          end
        end
        ST_CONV: begin
          if (miso_i) begin
            state_q <= ST_SHIFT;
          end else if (expired) begin
            state_q <= ST_IDLE;
            cs_n_o  <= 1'b1;
            busy_o  <= 1'b0;
            err_o   <= 1'b1;
          end
        end
        ST_SHIFT: begin
          if (rise_tick) rises_q <= rises_q + 1'b1;
          if (last_edge) begin
            state_q <= ST_IDLE;
            cs_n_o  <= 1'b1;
            busy_o  <= 1'b0;
            valid_o <= 1'b1;
            data_o  <= sr_q[PAY_W-1:SUB_W];
            sub_o   <= sr_q[SUB_W-1:0];
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sadc_reader_chk.sv
module sadc_reader_chk #(
  parameter int FRAME  = 13,
  parameter int DATA_W = 10,
  parameter int SUB_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              cs_n_o,
  input logic              sclk_o,
  input logic              busy_o,
  input logic              valid_o,
  input logic              err_o,
  input logic [DATA_W-1:0] data_o,
  input logic [SUB_W-1:0]  sub_o
);
  logic       sclk_d;
  logic [7:0] rise_cnt;

  always_ff @(posedge clk) begin
    if (rst || cs_n_o) begin
      rise_cnt <= '0;
    end else if (sclk_o && !sclk_d) begin
      rise_cnt <= rise_cnt + 1'b1;
    end
    sclk_d <= rst ? 1'b0 : sclk_o;
  end

  AST_START_IN_IDLE: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n_o) |-> $past(!busy_o && start_i)); // R2
  AST_BUSY_MATCHES_SELECT: assert property (@(posedge clk) disable iff (rst)
    busy_o == !cs_n_o); // R3
  AST_SCLK_ONLY_SELECTED: assert property (@(posedge clk) disable iff (rst)
    sclk_o |-> !cs_n_o); // R4
  AST_FRAME_LENGTH: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> rise_cnt == 8'(FRAME)); // R5
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o); // R7
  AST_VALID_RELEASES: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> cs_n_o && $past(!cs_n_o)); // R7
  AST_ERR_NO_CLOCKS: assert property (@(posedge clk) disable iff (rst)
    err_o |-> cs_n_o && !valid_o && rise_cnt == 8'd0); // R8
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> $stable(data_o) && $stable(sub_o)); // R9
endmodule

bind sadc_reader sadc_reader_chk #(
  .FRAME  (FRAME),
  .DATA_W (DATA_W),
  .SUB_W  (SUB_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start_i (start_i),
  .cs_n_o  (cs_n_o),
  .sclk_o  (sclk_o),
  .busy_o  (busy_o),
  .valid_o (valid_o),
  .err_o   (err_o),
  .data_o  (data_o),
  .sub_o   (sub_o)
);

// File: tb/sadc_reader_test.sv
module sadc_reader_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 2;
  localparam int T_OUT      = 40;
  localparam int FRAME      = 13;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, miso = 1'b0;
  logic cs_n, sclk, busy, valid, err;
  logic [9:0] data;
  logic [1:0] sub;

  sadc_reader #(.HALF_DIV(HALF), .TIMEOUT_CYC(T_OUT)) uut (
    .clk(clk), .rst(rst), .start_i(start), .miso_i(miso), .cs_n_o(cs_n),
    .sclk_o(sclk), .busy_o(busy), .valid_o(valid), .err_o(err),
    .data_o(data), .sub_o(sub));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { bit is_err; bit [9:0] d; bit [1:0] s; } exp_t;
  exp_t exp_q[$];

  int checks = 0, fails = 0, results = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Converter model
  bit [9:0] dev_d;
  bit [1:0] dev_s;
  int dev_conv;
  bit dev_never;
  int bit_idx;

  function automatic bit frame_bit(input int k);
    if (k == 0) return 1'b1;
    if (k >= 1 && k <= 10) return dev_d[10 - k];
    if (k == 11 || k == 12) return dev_s[12 - k];
    return 1'b0;
  endfunction

  always begin
    @(negedge cs_n);
    #1 miso = 1'b0;
    bit_idx = 0;
    if (!dev_never) begin
      repeat (dev_conv) @(posedge clk);
      #1 miso = 1'b1;
    end
  end

  always @(negedge sclk) begin
    #1;
    bit_idx = bit_idx + 1;
    miso = frame_bit(bit_idx);
  end

  // Monitor / scoreboard
  bit cs_prev = 1, sclk_prev = 0, bad_hs = 0, bad_per = 0;
  int rises = 0, since_rise = 0, low_cyc = 0, cs_falls = 0;
  bit [9:0] last_d = 0;
  bit [1:0] last_s = 0;

  always @(negedge clk) begin
    if (!rst) begin
      exp_t e;
      since_rise++;
      if (busy == cs_n) bad_hs = 1;
      if (sclk && cs_n) bad_hs = 1;
      if (!cs_n) low_cyc++;
      if (cs_prev && !cs_n) cs_falls++;
      if (sclk && !sclk_prev) begin
        if (rises > 0 && since_rise != 2*HALF) bad_per = 1;
        rises++;
        since_rise = 0;
      end
      if (valid || err) begin
        e = exp_q.pop_front();
        check(err == e.is_err, "R8 error flag", err, e.is_err);
        check(valid == !e.is_err, "R7 valid flag", valid, !e.is_err);
        check(!bad_hs && cs_n && !busy, "R3 select/busy handshake", bad_hs, 0);
        check(cs_falls == 1, "R2 one select fall per transfer", cs_falls, 1);
        if (e.is_err) begin
          check(rises == 0, "R5 no clocks on timeout", rises, 0);
          check(low_cyc == T_OUT, "R8 select low cycles", low_cyc, T_OUT);
          check(data == last_d, "R9 data held after timeout", data, last_d);
          check(sub == last_s, "R9 sub-bits held after timeout", sub, last_s);
        end else begin
          check(rises == FRAME, "R5 rising edge count", rises, FRAME);
          check(!bad_per, "R5 clock period", bad_per, 0);
          check(data == e.d, "R6 data value", data, e.d);
          check(sub == e.s, "R6 sub-bit value", sub, e.s);
          last_d = e.d;
          last_s = e.s;
        end
        rises = 0; low_cyc = 0; cs_falls = 0; bad_hs = 0; bad_per = 0;
        results++;
      end
      if (cs_n && !valid && !err && !busy && rises != 0) bad_hs = 1;
      cs_prev = cs_n;
      sclk_prev = sclk;
    end
  end

  // Check that valid lasts one cycle (R7)
  always @(negedge clk) begin
    if (!rst && valid) begin
      @(negedge clk);
      check(!valid, "R7 valid single cycle", valid, 0);
    end
  end

  task automatic do_read(input bit [9:0] d, input bit [1:0] s, input int conv,
                         input bit never, input bit glitch);
    exp_t e;
    int n;
    dev_d = d; dev_s = s; dev_conv = conv; dev_never = never;
    e.is_err = never; e.d = d; e.s = s;
    exp_q.push_back(e);
    n = results;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (glitch) begin
      repeat (3) @(negedge clk);
      start = 1'b1;   // R2: request while busy must be ignored
      @(negedge clk) start = 1'b0;
    end
    wait (results > n);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R3 watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(cs_n == 1'b1, "R1 cs_n in reset", cs_n, 1);
    check(sclk == 1'b0, "R1 sclk in reset", sclk, 0);
    check(!busy && !valid && !err, "R1 flags in reset", {busy, valid, err}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(cs_n && !sclk && !busy && !valid && !err, "R1 after reset", cs_n, 1);
    repeat (4) @(negedge clk);
    // R4: sclk quiet while converting
    fork
      begin
        dev_d = 10'h2A5; dev_s = 2'b10; dev_conv = 20; dev_never = 0;
      end
    join
    do_read(10'h2A5, 2'b10, 5, 0, 0);
    do_read(10'h000, 2'b00, 0, 0, 0);
    do_read(10'h3FF, 2'b11, 30, 0, 0);
    do_read(10'h155, 2'b01, 12, 0, 1);
    // R4: no sclk activity over a long wait, observed via rise count at the result
    do_read(10'h0F0, 2'b10, 35, 0, 0);
    do_read(10'h1C3, 2'b11, 0, 1, 0);   // timeout, R8 and R9
    do_read(10'h001, 2'b01, 3, 0, 0);
    do_read(10'h200, 2'b00, 8, 0, 0);
    check(exp_q.size() == 0, "R7 all results seen", exp_q.size(), 0);
    finish_run();
  end
endmodule